// File: doc/BRIEF.md
# Delayed Priority Interrupt Controller

This block merges fifteen interrupt sources into a single three-bit processor interrupt level. Each source has a request bit and an enable bit. Software sets or clears bits in either register through a small write port. A source counts as active when its request and enable bits are both set and the global enable is on. Six levels are used, and the sources are split unevenly across them. The highest-numbered source that has arrived sets the level.

A newly active source does not reach the processor at once. A per-source timer holds it back for a fixed number of cycles. While that timer runs, the block reports a valid request at level 0, which means "pending, not yet arrived". This is kept separate from "no request", which clears the valid flag. The registered level is compared each cycle with the processor's current priority mask. When the level is strictly higher, the block produces a one-cycle acknowledge, an exception vector, and the new mask value the processor should load.

Top module: `irq_arr_ctrl`

## Requirements
- R1: The request and enable registers are each written with a 16-bit word. Bit 15 = 1 ORs bits 14:0 into the register, and bit 15 = 0 clears the bits that are set in 14:0. A source i is active when request[i] and enable[i] are both 1.
- R2: Enable bit 14 is the global enable. While it is 0, no source is active and `lvl_valid_o` is 0, whatever the other bits hold.
- R3: Level map: sources 0 to 2 give level 1, source 3 gives 2, sources 4 to 6 give 3, sources 7 to 10 give 4, sources 11 and 12 give 5, and sources 13 and 14 give 6. When several sources have arrived, the highest-numbered one decides the level.
- R4: Suppose a source becomes active at clock edge W. Then `lvl_o` leaves that source out until edge W+DLY+2 (DLY=4) and shows its level from edge W+DLY+3 on, as long as the source stays active.
- R5: When a source's request or enable bit is cleared, its timer resets. If the bit is set again later, the full delay runs again.
- R6: `lvl_valid_o` goes to 1 one edge after any source becomes active and goes to 0 one edge after none is active. While valid is 1 and no active source has arrived, `lvl_o` is 0. While valid is 0, `lvl_o` is 0.
- R7: `ack_o` goes to 1 at an edge only if, just before that edge, `lvl_valid_o` is 1, `lvl_o` is strictly greater than `cpu_mask_i`, and `ack_o` is 0.
- R8: In an acknowledge cycle, `vec_o` = `lvl_o` + 24 and `mask_upd_o` = `lvl_o`, both taken from the cycle before. Outside acknowledge cycles both are 0.
- R9: `ack_o` is never 1 in two cycles in a row. If the mask is not raised, the acknowledge repeats every other cycle.
- R10: A change on `cpu_mask_i` is compared against the level at the very next edge. Raising the mask to the level or above stops acknowledges, and lowering it below the level starts them again.
- R11: After reset, all outputs are 0 and no source is pending or has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_req_i | input | 1 | Write strobe for the request register |
| wr_ena_i | input | 1 | Write strobe for the enable register |
| wr_data_i | input | 16 | Write word: bit 15 chooses set or clear, bits 14:0 select the bits |
| cpu_mask_i | input | 3 | Current processor priority mask |
| lvl_valid_o | output | 1 | At least one source is active |
| lvl_o | output | 3 | Arrived level (0 = pending only) |
| ack_o | output | 1 | Interrupt accepted, single-cycle pulse |
| vec_o | output | 8 | Exception vector, nonzero only with ack |
| mask_upd_o | output | 3 | New processor mask, nonzero only with ack |

## Verification
Directed runs set one source per level group to check the level map. They then stack a lower and a higher source to confirm that the highest source wins, and they time each arrival edge by edge. This separates the "pending" output from the "arrived" output. Turning the global enable off with requests still raised, and clearing a request and setting it again, show that the gate and the timer reset work on their own. Mask sweeps around the active level separate "strictly greater" from "greater or equal", and random write traffic with random masks exercises overlapping timers against a bench model.

// File: rtl/irq_arr_pkg.sv
package irq_arr_pkg;
  localparam int NSRC     = 15;
  localparam int LVL_W    = 3;
  localparam int WD_W     = NSRC + 1;
  localparam int VEC_W    = 8;
  localparam int VEC_BASE = 24;
  localparam int MASTER   = NSRC - 1;

  function automatic logic [LVL_W-1:0] src_lvl(input int i);
    if (i >= 13)     return 3'd6;
    else if (i >= 11) return 3'd5;
    else if (i >= 7)  return 3'd4;
    else if (i >= 4)  return 3'd3;
    else if (i == 3)  return 3'd2;
    else              return 3'd1;
  endfunction
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_arr_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_req_i,
  input  logic            wr_ena_i,
  input  logic [WD_W-1:0] wr_data_i,
  output logic [NSRC-1:0] req_o,
  output logic [NSRC-1:0] ena_o
);
  logic            set_w;
  logic [NSRC-1:0] bits_w;

  assign set_w  = wr_data_i[WD_W-1];
  assign bits_w = wr_data_i[NSRC-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o <= '0;
      ena_o <= '0;
    end else begin
      if (wr_req_i) req_o <= set_w ? (req_o | bits_w) : (req_o & ~bits_w);
      if (wr_ena_i) ena_o <= set_w ? (ena_o | bits_w) : (ena_o & ~bits_w);
    end
  end
endmodule

// File: rtl/irq_src_timer.sv
module irq_src_timer #(
  parameter int DLY = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  output logic arrived_o
);
  localparam int CNT_W = (DLY < 1) ? 1 : $clog2(DLY + 1);

  logic             pend_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= 1'b0;
      arrived_o <= 1'b0;
      cnt_q     <= '0;
    end else if (!active_i) begin
      pend_q    <= 1'b0;
      arrived_o <= 1'b0;
      cnt_q     <= '0;
    end else if (!pend_q && !arrived_o) begin
      pend_q <= 1'b1;
      cnt_q  <= '0;
    end else if (pend_q) begin
      if (cnt_q == CNT_W'(DLY)) begin
        pend_q    <= 1'b0;
        arrived_o <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio
  import irq_arr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  active_i,
  input  logic [NSRC-1:0]  arrived_i,
  output logic             valid_o,
  output logic [LVL_W-1:0] lvl_o
);
  logic [LVL_W-1:0] lvl_d;

  // ascending scan, later hit overrides: highest source wins
  always_comb begin
    lvl_d = '0;
    for (int i = 0; i < NSRC; i++)
      if (active_i[i] && arrived_i[i]) lvl_d = src_lvl(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      lvl_o   <= '0;
    end else begin
      valid_o <= |active_i;
      lvl_o   <= lvl_d;
    end
  end
endmodule

// File: rtl/irq_arr_ctrl.sv
module irq_arr_ctrl
  import irq_arr_pkg::*;
#(
  parameter int DLY = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_req_i,
  input  logic             wr_ena_i,
  input  logic [15:0]      wr_data_i,
  input  logic [2:0]       cpu_mask_i,
  output logic             lvl_valid_o,
  output logic [2:0]       lvl_o,
  output logic             ack_o,
  output logic [7:0]       vec_o,
  output logic [2:0]       mask_upd_o
);
  logic [NSRC-1:0] req_w, ena_w, active_w, arrived_w;
  logic            take_w;

  irq_regs u_regs (
    .clk_i, .rst_ni, .wr_req_i, .wr_ena_i, .wr_data_i,
    .req_o(req_w), .ena_o(ena_w)
  );

  assign active_w = req_w & ena_w & {NSRC{ena_w[MASTER]}};

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    irq_src_timer #(.DLY(DLY)) u_tmr (
      .clk_i, .rst_ni, .active_i(active_w[g]), .arrived_o(arrived_w[g])
    );
  end

  irq_prio u_prio (
    .clk_i, .rst_ni, .active_i(active_w), .arrived_i(arrived_w),
    .valid_o(lvl_valid_o), .lvl_o(lvl_o)
  );

  assign take_w = lvl_valid_o && (lvl_o > cpu_mask_i) && !ack_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o      <= 1'b0;
      vec_o      <= '0;
      mask_upd_o <= '0;
    end else begin
      ack_o      <= take_w;
      vec_o      <= take_w ? (VEC_W'(VEC_BASE) + VEC_W'(lvl_o)) : '0;
      mask_upd_o <= take_w ? lvl_o : '0;
    end
  end
endmodule

// File: rtl/irq_arr_chk.sv
module irq_arr_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] cpu_mask_i,
  input logic       master_i,
  input logic       lvl_valid_o,
  input logic [2:0] lvl_o,
  input logic       ack_o,
  input logic [7:0] vec_o,
  input logic [2:0] mask_upd_o
);
  a_r9_ack_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  a_r7_ack_above_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> ($past(lvl_valid_o) && ($past(lvl_o) > $past(cpu_mask_i))));

  a_r8_vec_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (vec_o == 8'd24 + {5'd0, mask_upd_o}) && (mask_upd_o != 3'd0));

  a_r8_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_o |-> (vec_o == 8'd0) && (mask_upd_o == 3'd0));

  a_r6_invalid_lvl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lvl_valid_o |-> (lvl_o == 3'd0));

  a_r2_master_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(master_i) && !master_i) |=> !lvl_valid_o);
endmodule

bind irq_arr_ctrl irq_arr_chk u_chk (
  .clk_i, .rst_ni, .cpu_mask_i, .master_i(ena_w[14]),
  .lvl_valid_o, .lvl_o, .ack_o, .vec_o, .mask_upd_o
);

// File: tb/irq_arr_ctrl_bench.sv
module irq_arr_ctrl_bench;
  localparam int DLY = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_req = 1'b0, wr_ena = 1'b0;
  logic [15:0] wr_data = '0;
  logic [2:0] mask = 3'd7;
  logic lvl_valid, ack;
  logic [2:0] lvl, mupd;
  logic [7:0] vec;

  irq_arr_ctrl #(.DLY(DLY)) u_irq_arr_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_req_i(wr_req), .wr_ena_i(wr_ena),
    .wr_data_i(wr_data), .cpu_mask_i(mask), .lvl_valid_o(lvl_valid),
    .lvl_o(lvl), .ack_o(ack), .vec_o(vec), .mask_upd_o(mupd)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string phase = "R11";

  logic [14:0] m_req = '0, m_ena = '0, m_act = '0;
  int age [15];
  logic p_val = 0, p_ack = 0;
  logic [2:0] p_lvl = 0, p_mupd = 0;
  logic [7:0] p_vec = 0;

  function automatic logic [2:0] lvl_of(input int s);
    case (s)
      13, 14: return 3'd6;
      11, 12: return 3'd5;
      7, 8, 9, 10: return 3'd4;
      4, 5, 6: return 3'd3;
      3: return 3'd2;
      default: return 3'd1;
    endcase
  endfunction

  function automatic logic [14:0] apply(input logic [14:0] r, input logic [15:0] d);
    return d[15] ? (r | d[14:0]) : (r & ~d[14:0]);
  endfunction

  task automatic chk(input string f, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d exp %0d at %0t", f, phase, got, exp, $time);
    end
  endtask

  task automatic step(input logic wr_r, input logic wr_e, input logic [15:0] d,
                      input logic [2:0] m);
    logic e_val, e_ack;
    logic [2:0] e_lvl, e_mupd;
    logic [7:0] e_vec;
    logic [14:0] nact;
    wr_req = wr_r; wr_ena = wr_e; wr_data = d; mask = m;
    e_val = |m_act;
    e_lvl = 3'd0;
    for (int i = 14; i >= 0; i--)
      if (e_lvl == 3'd0 && m_act[i] && age[i] >= DLY + 2) e_lvl = lvl_of(i);
    e_ack  = p_val && (p_lvl > m) && !p_ack;
    e_vec  = e_ack ? 8'(p_lvl + 24) : 8'd0;
    e_mupd = e_ack ? p_lvl : 3'd0;
    if (wr_r) m_req = apply(m_req, d);
    if (wr_e) m_ena = apply(m_ena, d);
    nact = m_ena[14] ? (m_req & m_ena) : 15'd0;
    for (int i = 0; i < 15; i++)
      age[i] = (m_act[i] && nact[i]) ? ((age[i] < 100) ? age[i] + 1 : age[i]) : 0;
    m_act = nact;
    @(posedge clk);
    @(negedge clk);
    chk("R6 valid", lvl_valid, e_val);
    chk("R4 R3 level", lvl, e_lvl);
    chk("R7 ack", ack, e_ack);
    chk("R8 vec", vec, e_vec);
    chk("R8 mask_upd", mupd, e_mupd);
    p_val = e_val; p_lvl = e_lvl; p_ack = e_ack; p_vec = e_vec; p_mupd = e_mupd;
  endtask

  task automatic idle(input int n, input logic [2:0] m);
    for (int k = 0; k < n; k++) step(1'b0, 1'b0, 16'h0, m);
  endtask

  initial begin
    for (int i = 0; i < 15; i++) age[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    phase = "R11";
    chk("R11 reset valid", lvl_valid, 0);
    chk("R11 reset level", lvl, 0);
    chk("R11 reset ack", ack, 0);
    chk("R11 reset vec", vec, 0);
    idle(2, 3'd7);

    phase = "R1";
    step(1'b0, 1'b1, 16'hFFFF, 3'd7);
    step(1'b1, 1'b0, 16'h8001, 3'd7);
    idle(9, 3'd7);
    phase = "R3";
    step(1'b1, 1'b0, 16'h8020, 3'd7);
    idle(9, 3'd7);
    step(1'b1, 1'b0, 16'h8008, 3'd7);
    idle(3, 3'd7);
    step(1'b1, 1'b0, 16'h8800, 3'd7);
    idle(9, 3'd7);
    step(1'b1, 1'b0, 16'hC000, 3'd7);
    idle(9, 3'd7);
    step(1'b1, 1'b0, 16'h4000, 3'd7);
    step(1'b1, 1'b0, 16'h0800, 3'd7);
    idle(4, 3'd7);

    phase = "R2";
    step(1'b0, 1'b1, 16'h4000, 3'd7);
    idle(4, 3'd7);
    step(1'b0, 1'b1, 16'hC000, 3'd7);
    idle(10, 3'd7);

    phase = "R5";
    step(1'b1, 1'b0, 16'h0020, 3'd7);
    step(1'b1, 1'b0, 16'h8020, 3'd7);
    idle(10, 3'd7);
    step(1'b0, 1'b1, 16'h0020, 3'd7);
    step(1'b0, 1'b1, 16'h8020, 3'd7);
    idle(10, 3'd7);

    phase = "R9";
    idle(6, 3'd0);
    phase = "R10";
    idle(4, 3'd3);
    idle(4, 3'd2);
    idle(3, 3'd4);
    idle(3, 3'd1);
    step(1'b1, 1'b0, 16'h7FFF, 3'd7);
    idle(3, 3'd0);

    phase = "R7 random";
    void'($urandom(32'd1234));
    for (int k = 0; k < 4000; k++) begin
      logic [15:0] d;
      int r;
      r = $urandom_range(0, 15);
      d = 16'(1 << $urandom_range(0, 14));
      if (($urandom_range(0, 3)) == 0) d = d | 16'(1 << $urandom_range(0, 14));
      d[15] = ($urandom_range(0, 2) != 0);
      if (r == 0)      step(1'b1, 1'b0, d, 3'($urandom_range(0, 7)));
      else if (r == 1) step(1'b0, 1'b1, d, 3'($urandom_range(0, 7)));
      else if (r == 2) step(1'b0, 1'b1, 16'hC000, 3'($urandom_range(0, 7)));
      else             step(1'b0, 1'b0, 16'h0, (r < 12) ? mask : 3'($urandom_range(0, 7)));
    end

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog %s: got 0 exp 1", phase);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule